// File: doc/BRIEF.md
# Fixed-Latency Register-Group Bridge

This block sits between an AXI4-Lite master and a cluster of simple register peripherals. On the master side it behaves as an ordinary AXI4-Lite slave. On the peripheral side it offers a stripped-down port with only two strobes, one for writes and one for reads. The peripheral never applies back-pressure and never returns a valid signal of its own. Each write arrives with its address, data and byte enables in a single cycle. Read data is taken from the peripheral a fixed number of clocks after the read strobe.

The parameter `LAT` selects the peripheral class. With `LAT` = 1 the peripheral shows the addressed register combinationally in the strobe cycle; this suits a single always-readable register. With `LAT` = 2 the peripheral registers its read multiplexer once, so the data appears one cycle after the strobe. The bridge rebuilds the write and read responses itself, delaying the strobes by `LAT` clocks. Any stall from the master on B or R is absorbed by response storage inside the bridge. New requests are refused while the number of outstanding requests on a channel equals `DEPTH`.

Write addresses and write data may reach the bridge in either order. A small joining state machine holds whichever half arrived first. Its states are `WJ_EMPTY` (nothing held), `WJ_ADDR_HELD` (address waiting for data) and `WJ_DATA_HELD` (data waiting for address). Its transitions are:
- EMPTY→ADDR_HELD when only AW completes.
- EMPTY→DATA_HELD when only W completes.
- ADDR_HELD→EMPTY when W completes.
- DATA_HELD→EMPTY when AW completes.
- EMPTY→EMPTY when both complete together or neither does.

Every transition back to EMPTY, together with the both-at-once case, issues one combined write.

Top module: `axfl_bridge`

## Requirements
- R1: After reset, `s_awready`, `s_wready` and `s_arready` are high, and `s_bvalid`, `s_rvalid`, `p_wr_valid` and `p_rd_valid` are low.
- R2: AW and W handshakes may occur in the same cycle or in either order, with any gap between them. Exactly one `p_wr_valid` pulse follows, in the cycle after the later handshake, carrying that address, data and strobe. No pulse appears before the pair is complete.
- R3: The register index on `p_wr_index` and `p_rd_index` is address bits [ADDR_W-1:OFF], where OFF = log2(DATA_W/8). The low OFF address bits are ignored.
- R4: With `s_bready` high, `s_bvalid` rises exactly `LAT` cycles after the `p_wr_valid` pulse, and `s_bresp` is 2'b00.
- R5: A read strobe `p_rd_valid` follows an AR handshake by one cycle. With `s_rready` high, `s_rvalid` rises exactly `LAT` cycles after that strobe. `s_rdata` then equals the value on `p_rd_data` in the cycle `LAT`-1 clocks after the strobe, and `s_rresp` is 2'b00.
- R6: While the master holds `s_bready` or `s_rready` low, up to `DEPTH` responses per channel are stored. Once the ready rises, all of them are delivered in request order, with no loss.
- R7: With `DEPTH` writes outstanding (accepted but B not yet taken), `s_awready` and `s_wready` are low. With `DEPTH` reads outstanding, `s_arready` is low. Each recovers after a response handshake.
- R8: A write pair and a read request accepted in the same cycle both issue to the peripheral side in the following cycle.
- R9: `p_wr_strb` carries `s_wstrb` unchanged, so a peripheral merging by byte lane updates only the enabled bytes.
- R10: Once raised, `s_bvalid` stays high, and `s_rvalid` stays high with `s_rdata` unchanged, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code, always OKAY |
| p_wr_valid | output | 1 | Combined write strobe to peripherals |
| p_wr_index | output | ADDR_W-OFF | Register index of the write |
| p_wr_data | output | DATA_W | Write data to peripherals |
| p_wr_strb | output | DATA_W/8 | Byte enables to peripherals |
| p_rd_valid | output | 1 | Read strobe to peripherals |
| p_rd_index | output | ADDR_W-OFF | Register index of the read |
| p_rd_data | input | DATA_W | Peripheral read data, sampled LAT-1 cycles after the strobe |

## Verification
The assertions assume that the master follows AXI4-Lite. Each valid stays high, with its payload unchanged, until its ready is seen. They also assume that the peripheral keeps its read data valid in the cycle the bridge samples it. The bench drives every channel from tasks that keep valids raised until the handshake is observed, and changes payloads only at falling edges. Its register-group model returns data at exactly the fixed latency of the configured class, so the sampling assumption holds throughout.

// File: rtl/axfl_pkg.sv
package axfl_pkg;

    // Joining state of the write path: which half of a write is parked.
    typedef enum logic [1:0] {
        WJ_EMPTY     = 2'd0,
        WJ_ADDR_HELD = 2'd1,
        WJ_DATA_HELD = 2'd2
    } wjoin_state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axfl_wr_join.sv
module axfl_wr_join
    import axfl_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                allow,
    input  logic                awvalid,
    input  logic [IDX_W-1:0]    aw_idx,
    output logic                awready,
    input  logic                wvalid,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic                wready,
    output logic                pair_done,
    output logic                issue_valid,
    output logic [IDX_W-1:0]    issue_idx,
    output logic [DATA_W-1:0]   issue_data,
    output logic [DATA_W/8-1:0] issue_strb
);

    localparam int STRB_W = DATA_W / 8;

    wjoin_state_t        state, state_nx;
    logic                aw_hs, w_hs;
    logic [IDX_W-1:0]    held_idx;
    logic [DATA_W-1:0]   held_data;
    logic [STRB_W-1:0]   held_strb;

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid && wready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WJ_EMPTY;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            WJ_EMPTY: begin
                if (aw_hs && !w_hs)      state_nx = WJ_ADDR_HELD;
                else if (w_hs && !aw_hs) state_nx = WJ_DATA_HELD;
            end
            WJ_ADDR_HELD: if (w_hs)  state_nx = WJ_EMPTY;
            WJ_DATA_HELD: if (aw_hs) state_nx = WJ_EMPTY;
            default:                 state_nx = WJ_EMPTY;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        awready   = allow && (state != WJ_ADDR_HELD);
        wready    = allow && (state != WJ_DATA_HELD);
        pair_done = 1'b0;
        unique case (state)
            WJ_EMPTY:     pair_done = aw_hs && w_hs;
            WJ_ADDR_HELD: pair_done = w_hs;
            WJ_DATA_HELD: pair_done = aw_hs;
            default:      pair_done = 1'b0;
        endcase
    end

    // Parking registers for the half that arrived first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_idx  <= '0;
            held_data <= '0;
            held_strb <= '0;
        end else begin
            if (aw_hs) held_idx <= aw_idx;
            if (w_hs) begin
                held_data <= wdata;
                held_strb <= wstrb;
            end
        end
    end

    // Combined write toward the peripherals, one cycle after the pair completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_idx   <= '0;
            issue_data  <= '0;
            issue_strb  <= '0;
        end else begin
            issue_valid <= pair_done;
            if (pair_done) begin
                issue_idx  <= aw_hs ? aw_idx : held_idx;
                issue_data <= w_hs  ? wdata  : held_data;
                issue_strb <= w_hs  ? wstrb  : held_strb;
            end
        end
    end

    AST_HELD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WJ_ADDR_HELD && $past(state) == WJ_ADDR_HELD) |-> $stable(held_idx)); // R2

    AST_ISSUE_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (state == WJ_EMPTY)); // R2

endmodule

// File: rtl/axfl_lat_pipe.sv
module axfl_lat_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);

    // Stage 0 coincides with the peripheral strobe; the last stage marks
    // the cycle in which the response is captured.
    logic [LAT-1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage[0] <= in_valid;
            for (int k = 1; k < LAT; k++) stage[k] <= stage[k-1];
        end
    end

    assign out_valid = stage[LAT-1];

endmodule

// File: rtl/axfl_resp_fifo.sv
module axfl_resp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + CNT_ONE;
            else if (!push && pop) count <= count - CNT_ONE;
        end
    end

    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CNT_FULL)); // R6

    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R6

endmodule

// File: rtl/axfl_bridge.sv
module axfl_bridge
    import axfl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LAT    = 2,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s_awvalid,
    output logic                       s_awready,
    input  logic [ADDR_W-1:0]          s_awaddr,
    input  logic                       s_wvalid,
    output logic                       s_wready,
    input  logic [DATA_W-1:0]          s_wdata,
    input  logic [DATA_W/8-1:0]        s_wstrb,
    output logic                       s_bvalid,
    input  logic                       s_bready,
    output logic [1:0]                 s_bresp,
    input  logic                       s_arvalid,
    output logic                       s_arready,
    input  logic [ADDR_W-1:0]          s_araddr,
    output logic                       s_rvalid,
    input  logic                       s_rready,
    output logic [DATA_W-1:0]          s_rdata,
    output logic [1:0]                 s_rresp,
    output logic                       p_wr_valid,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] p_wr_index,
    output logic [DATA_W-1:0]          p_wr_data,
    output logic [DATA_W/8-1:0]        p_wr_strb,
    output logic                       p_rd_valid,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] p_rd_index,
    input  logic [DATA_W-1:0]          p_rd_data
);

    localparam int STRB_W = DATA_W / 8;
    localparam int OFF    = $clog2(STRB_W);
    localparam int IDX_W  = ADDR_W - OFF;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic unused_addr_lsbs;
    assign unused_addr_lsbs = ^{s_awaddr[OFF-1:0], s_araddr[OFF-1:0]};

    // ---------------- write side ----------------
    logic             wr_allow, pair_done, wr_cap, b_hs;
    logic [CNT_W-1:0] wr_out, b_ready_cnt;

    assign wr_allow = (wr_out < CNT_MAX);
    assign b_hs     = s_bvalid && s_bready;
    assign s_bvalid = (b_ready_cnt != '0);
    assign s_bresp  = RESP_OKAY;

    axfl_wr_join #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_join (
        .clk         (clk),
        .rst_n       (rst_n),
        .allow       (wr_allow),
        .awvalid     (s_awvalid),
        .aw_idx      (s_awaddr[ADDR_W-1:OFF]),
        .awready     (s_awready),
        .wvalid      (s_wvalid),
        .wdata       (s_wdata),
        .wstrb       (s_wstrb),
        .wready      (s_wready),
        .pair_done   (pair_done),
        .issue_valid (p_wr_valid),
        .issue_idx   (p_wr_index),
        .issue_data  (p_wr_data),
        .issue_strb  (p_wr_strb)
    );

    axfl_lat_pipe #(.LAT(LAT)) u_wpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pair_done),
        .out_valid (wr_cap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_out      <= '0;
            b_ready_cnt <= '0;
        end else begin
            if (pair_done && !b_hs)      wr_out <= wr_out + CNT_ONE;
            else if (!pair_done && b_hs) wr_out <= wr_out - CNT_ONE;
            if (wr_cap && !b_hs)         b_ready_cnt <= b_ready_cnt + CNT_ONE;
            else if (!wr_cap && b_hs)    b_ready_cnt <= b_ready_cnt - CNT_ONE;
        end
    end

    // ---------------- read side ----------------
    logic             rd_allow, ar_hs, rd_cap, r_hs;
    logic [CNT_W-1:0] rd_out;

    assign rd_allow  = (rd_out < CNT_MAX);
    assign s_arready = rd_allow;
    assign ar_hs     = s_arvalid && s_arready;
    assign r_hs      = s_rvalid && s_rready;
    assign s_rresp   = RESP_OKAY;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_rd_valid <= 1'b0;
            p_rd_index <= '0;
            rd_out     <= '0;
        end else begin
            p_rd_valid <= ar_hs;
            if (ar_hs) p_rd_index <= s_araddr[ADDR_W-1:OFF];
            if (ar_hs && !r_hs)      rd_out <= rd_out + CNT_ONE;
            else if (!ar_hs && r_hs) rd_out <= rd_out - CNT_ONE;
        end
    end

    axfl_lat_pipe #(.LAT(LAT)) u_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ar_hs),
        .out_valid (rd_cap)
    );

    axfl_resp_fifo #(
        .W     (DATA_W),
        .DEPTH (DEPTH)
    ) u_rfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_cap),
        .push_data (p_rd_data),
        .pop       (r_hs),
        .out_valid (s_rvalid),
        .out_data  (s_rdata)
    );

    // ---------------- assertions ----------------
    AST_WR_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out <= CNT_MAX); // R7

    AST_RD_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out <= CNT_MAX); // R7

    AST_B_WITHIN_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        b_ready_cnt <= wr_out); // R6

    AST_NO_RESP_UNREQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> (rd_out != '0)); // R5

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R10

endmodule

// File: tb/axfl_bridge_tb_top.sv
module axfl_bridge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int LAT    = 2;
    localparam int DEPTH  = 4;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int NREG   = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
    logic [ADDR_W-1:0] s_awaddr = '0, s_araddr = '0;
    logic [31:0]       s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]        s_bresp, s_rresp;
    logic [31:0]       s_rdata;
    logic              p_wr_valid, p_rd_valid;
    logic [IDX_W-1:0]  p_wr_index, p_rd_index;
    logic [31:0]       p_wr_data, p_rd_data;
    logic [3:0]        p_wr_strb;

    axfl_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .p_wr_valid(p_wr_valid), .p_wr_index(p_wr_index), .p_wr_data(p_wr_data),
        .p_wr_strb(p_wr_strb), .p_rd_valid(p_rd_valid), .p_rd_index(p_rd_index),
        .p_rd_data(p_rd_data)
    );

    // Register-group model obeying the fixed-latency contract
    logic [31:0] regs   [NREG];
    logic [31:0] shadow [NREG];
    logic [31:0] rd_q = '0;

    always @(posedge clk) begin
        if (p_wr_valid)
            for (int b = 0; b < 4; b++)
                if (p_wr_strb[b]) regs[p_wr_index][8*b +: 8] <= p_wr_data[8*b +: 8];
        if (p_rd_valid) rd_q <= regs[p_rd_index];
    end
    assign p_rd_data = (LAT == 1) ? regs[p_rd_index] : rd_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic axi_wr(input int idx, input logic [1:0] lsb, input logic [31:0] data,
                          input logic [3:0] strb, input int aw_lag, input int w_lag,
                          input bit chk_lat, input string req);
        int c = 0;
        bit aw_done = 0, w_done = 0, early = 0;
        while (!(aw_done && w_done)) begin
            @(negedge clk);
            if (p_wr_valid) early = 1;
            s_awvalid = !aw_done && (c >= aw_lag);
            s_awaddr  = {idx[IDX_W-1:0], lsb};
            s_wvalid  = !w_done && (c >= w_lag);
            s_wdata   = data;
            s_wstrb   = strb;
            #1;
            if (s_awvalid && s_awready) aw_done = 1;
            if (s_wvalid && s_wready)   w_done = 1;
            c++;
        end
        for (int b = 0; b < 4; b++) if (strb[b]) shadow[idx][8*b +: 8] = data[8*b +: 8];
        @(negedge clk);
        s_awvalid = 0;
        s_wvalid  = 0;
        if (chk_lat) begin
            check(!early, req, "strobe before pair complete", 32'(early), 0);
            check(p_wr_valid, req, "write strobe", 32'(p_wr_valid), 1);
            check(p_wr_index == idx[IDX_W-1:0], "R3", "write index", 32'(p_wr_index), idx);
            check(p_wr_data == data, req, "write data", p_wr_data, data);
            check(p_wr_strb == strb, "R9", "write strobe bits", 32'(p_wr_strb), 32'(strb));
            for (int k = 1; k <= LAT; k++) begin
                @(negedge clk);
                check(s_bvalid == (k == LAT), "R4", $sformatf("bvalid at +%0d", k),
                      32'(s_bvalid), 32'(k == LAT));
            end
            check(s_bresp == 2'b00, "R4", "bresp", 32'(s_bresp), 0);
            @(negedge clk);
        end
    endtask

    task automatic axi_rd(input int idx, input bit chk_lat, input string req);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            s_arvalid = 1;
            s_araddr  = {idx[IDX_W-1:0], 2'b00};
            #1;
            if (s_arready) done = 1;
        end
        @(negedge clk);
        s_arvalid = 0;
        if (chk_lat) begin
            check(p_rd_valid && p_rd_index == idx[IDX_W-1:0], "R5", "read strobe/index",
                  32'(p_rd_index), idx);
            for (int k = 1; k <= LAT; k++) begin
                @(negedge clk);
                check(s_rvalid == (k == LAT), "R5", $sformatf("rvalid at +%0d", k),
                      32'(s_rvalid), 32'(k == LAT));
            end
            check(s_rdata == shadow[idx], req, "read data", s_rdata, shadow[idx]);
            check(s_rresp == 2'b00, "R5", "rresp", 32'(s_rresp), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(s_awready && s_wready && s_arready, "R1", "readies after reset",
              {29'b0, s_awready, s_wready, s_arready}, 32'h7);
        check(!s_bvalid && !s_rvalid && !p_wr_valid && !p_rd_valid, "R1", "valids after reset",
              {28'b0, s_bvalid, s_rvalid, p_wr_valid, p_rd_valid}, 0);
    endtask

    task automatic t_pairing;
        axi_wr(1, 2'b00, 32'h1111_0001, 4'hF, 0, 0, 1, "R2");
        axi_wr(2, 2'b00, 32'h2222_0002, 4'hF, 0, 3, 1, "R2");
        axi_wr(3, 2'b00, 32'h3333_0003, 4'hF, 2, 0, 1, "R2");
        axi_wr(7, 2'b11, 32'h7777_0007, 4'hF, 1, 1, 1, "R3");
        axi_rd(2, 1, "R5");
        axi_rd(7, 1, "R3");
    endtask

    task automatic t_strobes;
        axi_wr(5, 2'b00, 32'hAABB_CCDD, 4'hF, 0, 0, 1, "R9");
        axi_wr(5, 2'b00, 32'h1122_3344, 4'b0101, 0, 0, 1, "R9");
        check(shadow[5] == 32'hAA22_CC44, "R9", "merge model", shadow[5], 32'hAA22_CC44);
        axi_rd(5, 1, "R9");
    endtask

    task automatic t_wr_backpressure;
        int cnt = 0;
        s_bready = 0;
        for (int i = 0; i < DEPTH; i++)
            axi_wr(8 + i, 2'b00, 32'hC0DE_0000 + i, 4'hF, 0, 0, 0, "R6");
        check(!s_awready && !s_wready, "R7", "write readies at credit limit",
              {30'b0, s_awready, s_wready}, 0);
        repeat (LAT + 1) @(negedge clk);
        check(s_bvalid, "R6", "bvalid held while stalled", 32'(s_bvalid), 1);
        repeat (3) @(negedge clk);
        check(s_bvalid, "R10", "bvalid still held", 32'(s_bvalid), 1);
        s_bready = 1;
        repeat (8) begin
            if (s_bvalid) cnt++;
            @(negedge clk);
        end
        check(cnt == DEPTH, "R6", "write responses delivered", cnt, DEPTH);
        check(s_awready && s_wready, "R7", "write readies recovered",
              {30'b0, s_awready, s_wready}, 3);
    endtask

    task automatic t_rd_backpressure;
        s_rready = 0;
        for (int i = 0; i < DEPTH; i++) axi_rd(8 + i, 0, "R6");
        check(!s_arready, "R7", "arready at credit limit", 32'(s_arready), 0);
        repeat (LAT + 1) @(negedge clk);
        check(s_rvalid && s_rdata == shadow[8], "R6", "first stalled read", s_rdata, shadow[8]);
        repeat (3) @(negedge clk);
        check(s_rvalid && s_rdata == shadow[8], "R10", "rdata held", s_rdata, shadow[8]);
        s_rready = 1;
        for (int i = 1; i < DEPTH; i++) begin
            @(negedge clk);
            check(s_rvalid && s_rdata == shadow[8 + i], "R6", $sformatf("queued read %0d", i),
                  s_rdata, shadow[8 + i]);
        end
        @(negedge clk);
        check(!s_rvalid, "R6", "read queue drained", 32'(s_rvalid), 0);
        check(s_arready, "R7", "arready recovered", 32'(s_arready), 1);
    endtask

    task automatic t_concurrent;
        @(negedge clk);
        s_awvalid = 1; s_awaddr = {6'd20, 2'b00};
        s_wvalid  = 1; s_wdata  = 32'h5A5A_1234; s_wstrb = 4'hF;
        s_arvalid = 1; s_araddr = {6'd9, 2'b00};
        #1;
        check(s_awready && s_wready && s_arready, "R8", "all readies together",
              {29'b0, s_awready, s_wready, s_arready}, 32'h7);
        shadow[20] = 32'h5A5A_1234;
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
        check(p_wr_valid && p_rd_valid, "R8", "both strobes issued",
              {30'b0, p_wr_valid, p_rd_valid}, 3);
        repeat (LAT) @(negedge clk);
        check(s_bvalid && s_rvalid, "R8", "both responses", {30'b0, s_bvalid, s_rvalid}, 3);
        check(s_rdata == shadow[9], "R8", "concurrent read data", s_rdata, shadow[9]);
        @(negedge clk);
        axi_rd(20, 1, "R8");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            regs[i]   = '0;
            shadow[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_pairing();
        t_strobes();
        t_wr_backpressure();
        t_rd_backpressure();
        t_concurrent();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule